// File: doc/BRIEF.md
# DRAM entropy cell profiler

The profiler searches one DRAM row for cells that read back unreliably when the activate-to-read delay is made shorter than the device needs. A cell that fails about half the time under that abuse is a good raw entropy source. The block first stores a known word in the row under test, using the normal activate-to-read delay. It then runs a configurable number of trials. Each trial opens the row with its own activate, reads it after a deliberately shortened delay, and closes it with a precharge. For every bit of the word, the block counts the trials in which the bit came back different from the stored value.

When the trials are finished, each bit whose failure count falls inside a configurable inclusive window is flagged. The block reports a bitmask of the flagged bits, the number of flagged bits, and a single-cycle completion strobe. It drives a plain command port (activate, write, read, precharge). Read data comes back on a strobed return path after whatever latency the memory has. The row, stored word, trial count, all four delays and the window bounds are taken from configuration inputs at the moment a run is launched.

Top module: `entropy_cell_profiler`

## Requirements
- R1: After reset the block is idle. It issues no command, and `busy`, `done`, `rng_mask` and `rng_count` are all zero.
- R2: A `start` seen while idle launches a run and captures every `cfg_*` input at that edge. A `start` seen while `busy` has no effect on the command stream or on the results.
- R3: A run opens with ACT, then WR carrying `cfg_pattern` after exactly `cfg_trcd_full` idle cycles, then PRE after exactly `cfg_twr` idle cycles. `cmd_op` encodes ACT=0, WR=1, RD=2, PRE=3, and every command carries `cfg_row`.
- R4: In every trial, RD follows the trial's own ACT after exactly `cfg_trcd_cut` idle cycles. Every trial ACT follows the previous PRE after exactly `cfg_trp` idle cycles.
- R5: Each trial runs in the order ACT, RD, wait for `rd_valid`, and then PRE in the cycle right after the return. Exactly `cfg_trials` trials run, and a count of zero goes straight to evaluation after the opening PRE.
- R6: The failure count of bit i rises by one on each returned word where bit i differs from the stored pattern. The count saturates at 1023 and never wraps.
- R7: `rd_valid` is ignored in any cycle where no read return is awaited, including the cycle of a trial ACT.
- R8: Bit i of `rng_mask` is set exactly when its failure count lies within the inclusive range `cfg_win_lo` to `cfg_win_hi`.
- R9: `done` is high for one cycle, exactly `cfg_trp`+2 cycles after the final PRE. `rng_mask` and `rng_count` are valid in that cycle and hold until the next launch. `rng_count` equals the number of set mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request |
| cfg_row | input | ROW_W | Row under test |
| cfg_pattern | input | DATA_W | Word stored before the trials |
| cfg_trials | input | TRIAL_W | Number of trials |
| cfg_trcd_full | input | DLY_W | Idle cycles from ACT to WR |
| cfg_trcd_cut | input | DLY_W | Shortened idle cycles from ACT to RD |
| cfg_twr | input | DLY_W | Idle cycles from WR to PRE |
| cfg_trp | input | DLY_W | Idle cycles after PRE |
| cfg_win_lo | input | CNT_W | Lowest qualifying failure count |
| cfg_win_hi | input | CNT_W | Highest qualifying failure count |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | Command code |
| cmd_row | output | ROW_W | Row address of the command |
| cmd_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read return strobe |
| rd_data | input | DATA_W | Returned word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid strobe |
| rng_mask | output | DATA_W | Qualifying bit positions |
| rng_count | output | PC_W | Number of qualifying bits |

## Verification
Two events can land in the same cycle: the issue of a trial activate and a return strobe on the read path. A correct profiler must ignore that strobe while still opening the row. The bench provokes the collision in one run. It raises `rd_valid` with a fully inverted word in exactly the cycles where the command port shows a trial ACT. It then judges the result in two ways. The per-cycle command model must see no disturbance in command order or spacing. The final mask and count must match a reference that counted only the genuine returns, with the window set so that any extra counted failure would change the flagged set.

// File: rtl/entropy_cell_profiler.sv
module entropy_cell_profiler #(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 14,
  parameter int CNT_W   = 10,
  parameter int TRIAL_W = 11,
  parameter int DLY_W   = 8,
  localparam int PC_W   = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROW_W-1:0]   cfg_row,
  input  logic [DATA_W-1:0]  cfg_pattern,
  input  logic [TRIAL_W-1:0] cfg_trials,
  input  logic [DLY_W-1:0]   cfg_trcd_full,
  input  logic [DLY_W-1:0]   cfg_trcd_cut,
  input  logic [DLY_W-1:0]   cfg_twr,
  input  logic [DLY_W-1:0]   cfg_trp,
  input  logic [CNT_W-1:0]   cfg_win_lo,
  input  logic [CNT_W-1:0]   cfg_win_hi,
  output logic               cmd_valid,
  output logic [1:0]         cmd_op,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [DATA_W-1:0]  cmd_wdata,
  input  logic               rd_valid,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rng_mask,
  output logic [PC_W-1:0]    rng_count
);
  localparam logic [1:0] OP_ACT = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_PRE = 2'd3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_IACT, S_IWR, S_PRE, S_ACT, S_RD, S_DATA, S_WAIT, S_EVAL
  } state_t;

  state_t             state, ret_q, step_ret;
  logic [DLY_W-1:0]   timer, step_dly;
  logic [TRIAL_W-1:0] trial, trials_q;
  logic [ROW_W-1:0]   row_q;
  logic [DATA_W-1:0]  pat_q, mask_nx;
  logic [DLY_W-1:0]   full_q, cut_q, twr_q, trp_q;
  logic [CNT_W-1:0]   lo_q, hi_q;
  logic [PC_W-1:0]    pop_nx;
  logic               launch, capture;

  assign launch    = (state == S_IDLE) && start;
  assign capture   = (state == S_DATA) && rd_valid;
  assign busy      = (state != S_IDLE);
  assign cmd_row   = row_q;
  assign cmd_wdata = pat_q;

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_ACT;
    step_dly  = '0;
    step_ret  = S_IDLE;
    case (state)
      S_IACT: begin step_dly = full_q; step_ret = S_IWR; end
      S_IWR:  begin cmd_op = OP_WR; step_dly = twr_q; step_ret = S_PRE; end
      S_PRE:  begin
        cmd_op   = OP_PRE;
        step_dly = trp_q;
        step_ret = (trial == trials_q) ? S_EVAL : S_ACT;
      end
      S_ACT:  begin step_dly = cut_q; step_ret = S_RD; end
      S_RD:   begin cmd_op = OP_RD; step_ret = S_DATA; end
      default: cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ret_q     <= S_IDLE;
      timer     <= '0;
      trial     <= '0;
      trials_q  <= '0;
      row_q     <= '0;
      pat_q     <= '0;
      full_q    <= '0;
      cut_q     <= '0;
      twr_q     <= '0;
      trp_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      done      <= 1'b0;
      rng_mask  <= '0;
      rng_count <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          row_q     <= cfg_row;
          pat_q     <= cfg_pattern;
          trials_q  <= cfg_trials;
          full_q    <= cfg_trcd_full;
          cut_q     <= cfg_trcd_cut;
          twr_q     <= cfg_twr;
          trp_q     <= cfg_trp;
          lo_q      <= cfg_win_lo;
          hi_q      <= cfg_win_hi;
          trial     <= '0;
          rng_mask  <= '0;
          rng_count <= '0;
          state     <= S_IACT;
        end
        S_WAIT: begin
          if (timer <= DLY_W'(1)) state <= ret_q;
          else timer <= timer - DLY_W'(1);
        end
        S_DATA: if (rd_valid) begin
          trial <= trial + TRIAL_W'(1);
          state <= S_PRE;
        end
        S_EVAL: begin
          rng_mask  <= mask_nx;
          rng_count <= pop_nx;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: begin
          if (step_dly == '0) begin
            state <= step_ret;
          end else begin
            state <= S_WAIT;
            timer <= step_dly;
            ret_q <= step_ret;
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic [CNT_W-1:0] fails;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fails <= '0;
      else if (launch)
        fails <= '0;
      else if (capture && (rd_data[i] != pat_q[i]) && (fails != CNT_MAX))
        fails <= fails + CNT_W'(1);
    end
    assign mask_nx[i] = (fails >= lo_q) && (fails <= hi_q);
  end

  always_comb begin
    pop_nx = '0;
    for (int i = 0; i < DATA_W; i++) pop_nx = pop_nx + PC_W'(mask_nx[i]);
  end
endmodule

// File: rtl/entropy_cell_profiler_chk.sv
module entropy_cell_profiler_chk #(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 8,
  localparam int PC_W  = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DLY_W-1:0]  cfg_trcd_cut,
  input logic [DLY_W-1:0]  cfg_trp,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rng_mask,
  input logic [PC_W-1:0]   rng_count
);
  logic [1:0]       last_op;
  logic [15:0]      gap;
  logic             first_act;
  logic [DLY_W-1:0] cut_l, trp_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op   <= 2'd3;
      gap       <= '0;
      first_act <= 1'b0;
      cut_l     <= '0;
      trp_l     <= '0;
    end else begin
      if (!busy && start) begin
        cut_l     <= cfg_trcd_cut;
        trp_l     <= cfg_trp;
        first_act <= 1'b1;
      end
      if (cmd_valid) begin
        last_op <= cmd_op;
        gap     <= '0;
        if (cmd_op == 2'd0) first_act <= 1'b0;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
    end
  end

  a_r5_rd_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> (last_op == 2'd0));

  a_r5_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |-> (last_op == 2'd3));

  a_r4_cut_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> (gap == 16'(cut_l)));

  a_r4_trp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && !first_act) |-> (gap == 16'(trp_l)));

  a_r2_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(rng_count) == $countones(rng_mask)));
endmodule

bind entropy_cell_profiler entropy_cell_profiler_chk #(
  .DATA_W(DATA_W),
  .DLY_W(DLY_W)
) u_chk (.*);

// File: tb/sim_entropy_cell_profiler.sv
module sim_entropy_cell_profiler;
  localparam int CLK_PERIOD = 10;
  localparam int RD_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] cfg_row = '0;
  logic [15:0] cfg_pattern = '0;
  logic [10:0] cfg_trials = '0;
  logic [7:0]  cfg_trcd_full = '0, cfg_trcd_cut = '0, cfg_twr = '0, cfg_trp = '0;
  logic [9:0]  cfg_win_lo = '0, cfg_win_hi = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [13:0] cmd_row;
  logic [15:0] cmd_wdata;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        busy, done;
  logic [15:0] rng_mask;
  logic [4:0]  rng_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  entropy_cell_profiler u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_row(cfg_row), .cfg_pattern(cfg_pattern), .cfg_trials(cfg_trials),
    .cfg_trcd_full(cfg_trcd_full), .cfg_trcd_cut(cfg_trcd_cut),
    .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
    .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .rng_mask(rng_mask), .rng_count(rng_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit go = 0, poke = 0, inject = 0, running = 0, finished = 0;
  int due = -1, due_done = -1, ret_at = -1, trials_done = 0;
  logic [1:0] exp_op = 2'd0;
  bit init_ph = 0;
  int ref_cnt [16];
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] exp_mask = '0;
  string final_tag = "R8";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fvec(input int k, input logic [15:0] l);
    logic [15:0] f;
    f[0]  = 1'b0;
    f[1]  = 1'b1;
    f[2]  = (k % 2) == 0;
    f[3]  = (k % 3) == 0;
    f[4]  = l[0];
    f[5]  = (k % 4) != 0;
    f[6]  = (k % 10) < 4;
    f[7]  = (k % 20) < 9;
    f[8]  = (k % 20) < 11;
    f[9]  = (k % 1000) < 449;
    f[10] = (k % 1000) < 551;
    f[15:11] = l[15:11];
    return f;
  endfunction

  always @(negedge clk) begin : model
    bit ev;
    logic [15:0] f;
    int pc;
    string tag;
    if (rst_n) begin
      cyc = cyc + 1;
      rd_valid = 1'b0;
      start = 1'b0;
      if (go) begin
        go = 0;
        start = 1'b1;
        due = cyc + 1; exp_op = 2'd0; init_ph = 1;
        trials_done = 0; due_done = -1; ret_at = -1;
        for (int i = 0; i < 16; i++) ref_cnt[i] = 0;
        running = 1;
      end else if (poke) begin
        poke = 0;
        start = 1'b1;
      end
      if (running) begin
        ev = (cyc == due);
        tag = init_ph ? "R3" : (exp_op == 2'd2 ? "R4" : "R5");
        if (cmd_valid && !ev) tag = "R2";
        if (cmd_valid !== ev || (ev && cmd_op !== exp_op))
          chk(0, tag, "command slot/op", {cmd_valid, cmd_op}, {ev, exp_op});
        if (ev) begin
          chk(cmd_row == cfg_row, "R3", "row address", cmd_row, cfg_row);
          case (exp_op)
            2'd0: if (init_ph) begin
                    due = cyc + cfg_trcd_full + 1; exp_op = 2'd1;
                  end else begin
                    due = cyc + cfg_trcd_cut + 1; exp_op = 2'd2;
                    if (inject) begin rd_valid = 1'b1; rd_data = ~cfg_pattern; end
                  end
            2'd1: begin
                    chk(cmd_wdata == cfg_pattern, "R3", "write data", cmd_wdata, cfg_pattern);
                    due = cyc + cfg_twr + 1; exp_op = 2'd3; init_ph = 0;
                  end
            2'd2: begin ret_at = cyc + RD_LAT; due = ret_at + 1; exp_op = 2'd3; end
            default: begin
                    if (trials_done == int'(cfg_trials)) begin
                      due_done = cyc + cfg_trp + 2; due = -1;
                    end else begin
                      due = cyc + cfg_trp + 1; exp_op = 2'd0;
                    end
                  end
          endcase
        end
        if (cyc == ret_at) begin
          f = fvec(trials_done, lfsr);
          rd_valid = 1'b1;
          rd_data = cfg_pattern ^ f;
          for (int i = 0; i < 16; i++) if (f[i] && ref_cnt[i] < 1023) ref_cnt[i]++;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          trials_done++;
        end
        if (done !== (cyc == due_done))
          chk(0, "R9", "done timing", done, cyc == due_done);
        if (cyc == due_done) begin
          pc = 0;
          for (int i = 0; i < 16; i++) begin
            exp_mask[i] = (ref_cnt[i] >= int'(cfg_win_lo)) && (ref_cnt[i] <= int'(cfg_win_hi));
            pc += int'(exp_mask[i]);
          end
          chk(rng_mask == exp_mask, final_tag, "mask", rng_mask, exp_mask);
          chk(int'(rng_count) == pc, "R9", "count", rng_count, pc);
          running = 0;
          finished = 1;
        end
      end else if (cmd_valid) begin
        chk(0, "R2", "command while idle", cmd_op, 0);
      end
    end
  end

  task automatic run(input int trials, input logic [15:0] pat, input int full, input int cut,
                     input int twr, input int trp, input int lo, input int hi,
                     input bit do_poke, input bit do_inj, input string tag);
    cfg_row = 14'(trials + 37);
    cfg_pattern = pat;
    cfg_trials = 11'(trials);
    cfg_trcd_full = 8'(full); cfg_trcd_cut = 8'(cut);
    cfg_twr = 8'(twr); cfg_trp = 8'(trp);
    cfg_win_lo = 10'(lo); cfg_win_hi = 10'(hi);
    inject = do_inj;
    final_tag = tag;
    finished = 0;
    @(posedge clk);
    go = 1;
    if (do_poke) begin
      repeat (300) @(posedge clk);
      poke = 1;
    end
    wait (finished);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(rng_mask == 0, "R1", "mask after reset", rng_mask, 0);
    chk(rng_count == 0, "R1", "count after reset", rng_count, 0);

    // R8 window 450..550 with boundary bits; start pulse mid-run for R2
    run(1000, 16'hA5C3, 5, 2, 3, 4, 450, 550, 1, 0, "R8");
    chk(rng_mask[7] == 1, "R8", "bit at low bound", rng_mask[7], 1);
    chk(rng_mask[8] == 1, "R8", "bit at high bound", rng_mask[8], 1);
    chk(rng_mask[9] == 0, "R8", "bit below window", rng_mask[9], 0);
    chk(rng_mask[10] == 0, "R8", "bit above window", rng_mask[10], 0);
    chk(rng_mask[2] == 1, "R8", "half-rate bit", rng_mask[2], 1);
    repeat (20) @(negedge clk);
    chk(rng_mask == exp_mask, "R9", "mask held after done", rng_mask, exp_mask);

    // R6 saturation with R7 strobes colliding with trial ACT, zero delays
    run(1100, 16'hFFFF, 0, 0, 0, 0, 1023, 1023, 0, 1, "R7");
    chk(rng_mask == 16'h0002, "R6", "only saturated bit flagged", rng_mask, 16'h0002);
    chk(rng_count == 1, "R6", "saturated count", rng_count, 1);

    // R5 zero trials: every count is zero
    run(0, 16'h1234, 1, 1, 1, 2, 0, 0, 0, 0, "R5");
    chk(rng_mask == 16'hFFFF, "R5", "zero-trial mask", rng_mask, 16'hFFFF);
    chk(rng_count == 16, "R5", "zero-trial count", rng_count, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule